// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

This block is a first-in first-out buffer for 18-bit words. The producer and the consumer run on separate clocks, which may be unrelated or may be the same clock. The depth is a power of two between 256 and 4096 words and is set by a parameter. Writes and reads are both requested by active-low enables. A load control gates both enables: when the load control is low, the buffer does neither operation, because that state is used by a neighbouring block to program the thresholds.

Five active-low flags report the fill state. Full, half-full and almost-full are produced on the write clock. Empty and almost-empty are produced on the read clock. The almost-empty and almost-full thresholds are two 12-bit offsets that a separate offset-register block supplies.

The output is a register. Every word must be fetched with the read enable, including the first word after the buffer was empty. An output-enable control places the data output in high impedance.

Top module: `dcf_fifo`

## Requirements
- R1: Data is 18 bits wide. DEPTH is a power of two from 256 to 4096. Words leave in the order in which they were accepted.
- R2: While rst_n is low, both pointers return to the first location and the output register reads all zeros.
- R3: While in reset, full_n, half_n and afull_n read 1, and empty_n and aempty_n read 0.
- R4: A word is stored on a rising wr_clk edge only when wr_en_n=0, ld_n=1 and the buffer is not full. A write attempt while full is ignored, so nothing is overwritten or lost.
- R5: The output register loads the oldest word on a rising rd_clk edge only when rd_en_n=0, ld_n=1 and the buffer is not empty. In every other case it keeps its value.
- R6: A word written into an empty buffer does not appear at dout until it has been requested with rd_en_n.
- R7: A read attempt while empty is ignored. The output and the read position do not change.
- R8: full_n is produced on wr_clk and empty_n on rd_clk. Each pointer crosses to the other domain as a gray code that changes by at most one bit per edge. Each flag reaches its settled value within a few cycles of its own clock.
- R9: With oe_n=1, dout is released (high impedance). With oe_n=0, dout carries the output register.
- R10: aempty_n is 0 exactly when the stored word count is at or below empty_ofs.
- R11: half_n is 0 exactly when the stored word count is greater than DEPTH/2.
- R12: afull_n is 0 exactly when the free space (DEPTH minus the count) is at or below full_ofs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 18 | Write data |
| wr_en_n | input | 1 | Active-low write request |
| rd_en_n | input | 1 | Active-low read request |
| ld_n | input | 1 | Load control; must be 1 for reads and writes |
| oe_n | input | 1 | Active-low output enable |
| empty_ofs | input | 12 | Almost-empty threshold |
| full_ofs | input | 12 | Almost-full threshold |
| dout | output | 18 | Registered read data, tri-stated by oe_n |
| full_n | output | 1 | Active-low full flag (write clock) |
| empty_n | output | 1 | Active-low empty flag (read clock) |
| half_n | output | 1 | Active-low half-full flag (write clock) |
| afull_n | output | 1 | Active-low almost-full flag (write clock) |
| aempty_n | output | 1 | Active-low almost-empty flag (read clock) |

## Verification
The hardest state to reach from the ports is a completely full buffer that still receives write requests. This has to happen while the read side is stale by a few synchronizer stages, and the overflow must then be shown to have had no effect. The bench uses unrelated clock periods and fills the buffer to exactly DEPTH words while stepping through the half-full and almost-full boundaries. It waits for the flags to settle and checks each one against a queue model. It then presses the write enable with a marker word and drains the whole buffer, checking the order. The marker must never appear in the drained data.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DW = 18;
  localparam int OW = 12;
  typedef logic [DW-1:0] word_t;
  typedef logic [OW-1:0] ofs_t;
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign srst_n = s1_q;
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] m_q, s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      s_q <= '0;
    end else begin
      m_q <= d;
      s_q <= m_q;
    end
  end

  assign q = s_q;
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          ld_n,
  input  word_t         din,
  input  ofs_t          full_ofs,
  input  logic [PW-1:0] rgray_s,
  input  logic [AW-1:0] rd_addr,
  output word_t         rd_word,
  output logic [PW-1:0] wgray,
  output logic          full_n,
  output logic          half_n,
  output logic          afull_n
);
  localparam int CW = (PW > OW) ? PW : OW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  word_t         mem [DEPTH];
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d, rbin_s, cnt_d, free_d;
  logic          full_q, full_d, half_q, half_d, afull_q, afull_d, wr_ok;

  always_comb begin
    wr_ok   = !wr_en_n && ld_n && !full_q;
    wbin_d  = wbin_q + PW'(wr_ok);
    wgray_d = wbin_d ^ (wbin_d >> 1);
    rbin_s  = g2b(rgray_s);
    cnt_d   = wbin_d - rbin_s;
    free_d  = DEPTH_P - cnt_d;
    full_d  = (cnt_d == DEPTH_P);
    half_d  = (cnt_d > HALF_P);
    afull_d = (CW'(free_d) <= CW'(full_ofs));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      half_q  <= 1'b0;
      afull_q <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      full_q  <= full_d;
      half_q  <= half_d;
      afull_q <= afull_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wbin_q[AW-1:0]] <= din;
  end

  assign rd_word = mem[rd_addr];
  assign wgray   = wgray_q;
  assign full_n  = !full_q;
  assign half_n  = !half_q;
  assign afull_n = !afull_q;
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic          ld_n,
  input  ofs_t          empty_ofs,
  input  logic [PW-1:0] wgray_s,
  input  word_t         rd_word,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rgray,
  output word_t         q,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int CW = (PW > OW) ? PW : OW;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d, wbin_s, cnt_d;
  logic          empty_q, empty_d, aempty_q, aempty_d, rd_ok;
  word_t         q_q, q_d;

  always_comb begin
    rd_ok    = !rd_en_n && ld_n && !empty_q;
    rbin_d   = rbin_q + PW'(rd_ok);
    rgray_d  = rbin_d ^ (rbin_d >> 1);
    wbin_s   = g2b(wgray_s);
    cnt_d    = wbin_s - rbin_d;
    empty_d  = (cnt_d == '0);
    aempty_d = (CW'(cnt_d) <= CW'(empty_ofs));
    q_d      = rd_ok ? rd_word : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
      q_q      <= '0;
    end else begin
      rbin_q   <= rbin_d;
      rgray_q  <= rgray_d;
      empty_q  <= empty_d;
      aempty_q <= aempty_d;
      q_q      <= q_d;
    end
  end

  assign rd_addr  = rbin_q[AW-1:0];
  assign rgray    = rgray_q;
  assign q        = q_q;
  assign empty_n  = !empty_q;
  assign aempty_n = !aempty_q;
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wr_en_n,
  input  logic          rd_en_n,
  input  logic          ld_n,
  input  logic          oe_n,
  input  logic [OW-1:0] empty_ofs,
  input  logic [OW-1:0] full_ofs,
  output logic [DW-1:0] dout,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_n,
  output logic          afull_n,
  output logic          aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wr_srst_n, rd_srst_n;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] rd_addr;
  word_t         rd_word, rd_q;

  dcf_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_srst_n));
  dcf_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_srst_n));

  dcf_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wr_srst_n), .d(rgray), .q(rgray_s));
  dcf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rd_srst_n), .d(wgray), .q(wgray_s));

  dcf_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(wr_srst_n), .wr_en_n(wr_en_n), .ld_n(ld_n),
    .din(din), .full_ofs(full_ofs), .rgray_s(rgray_s), .rd_addr(rd_addr),
    .rd_word(rd_word), .wgray(wgray), .full_n(full_n), .half_n(half_n),
    .afull_n(afull_n)
  );

  dcf_rd_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(rd_srst_n), .rd_en_n(rd_en_n), .ld_n(ld_n),
    .empty_ofs(empty_ofs), .wgray_s(wgray_s), .rd_word(rd_word),
    .rd_addr(rd_addr), .rgray(rgray), .q(rd_q), .empty_n(empty_n),
    .aempty_n(aempty_n)
  );

  assign dout = oe_n ? {DW{1'bz}} : rd_q;
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int DEPTH = 256,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          rd_en_n,
  input logic          full_n,
  input logic          empty_n,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic [17:0]   rd_q
);
  // R4
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wgray));

  // R7
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rd_q));

  // R5
  idle_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_en_n |=> $stable(rd_q));

  // R8
  wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R8
  rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind dcf_fifo dcf_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n),
  .full_n(full_n), .empty_n(empty_n), .wgray(wgray), .rgray(rgray),
  .rd_q(rd_q)
);

// File: tb/dcf_fifo_test.sv
module dcf_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DEPTH      = 256;
  localparam logic [11:0] E_OFS = 12'd3;
  localparam logic [11:0] F_OFS = 12'd5;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic rst_n, wr_en_n, rd_en_n, ld_n, oe_n;
  logic [17:0] din;
  wire  [17:0] dout;
  logic full_n, empty_n, half_n, afull_n, aempty_n;

  int tests = 0, fails = 0;
  logic [17:0] model[$];
  logic [17:0] last_out;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  dcf_fifo #(.DEPTH(DEPTH)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .din(din),
    .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .ld_n(ld_n), .oe_n(oe_n),
    .empty_ofs(E_OFS), .full_ofs(F_OFS), .dout(dout), .full_n(full_n),
    .empty_n(empty_n), .half_n(half_n), .afull_n(afull_n), .aempty_n(aempty_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic check_flags(input string tag);
    int n = model.size();
    chk(full_n   == !(n == DEPTH),          {tag, " R8 full_n"},   32'(full_n),   32'(!(n == DEPTH)));
    chk(empty_n  == !(n == 0),              {tag, " R8 empty_n"},  32'(empty_n),  32'(!(n == 0)));
    chk(half_n   == !(n > DEPTH/2),         {tag, " R11 half_n"},  32'(half_n),   32'(!(n > DEPTH/2)));
    chk(afull_n  == !(DEPTH - n <= int'(F_OFS)), {tag, " R12 afull_n"}, 32'(afull_n), 32'(!(DEPTH - n <= int'(F_OFS))));
    chk(aempty_n == !(n <= int'(E_OFS)),    {tag, " R10 aempty_n"}, 32'(aempty_n), 32'(!(n <= int'(E_OFS))));
  endtask

  task automatic fill(input int n, input logic [17:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en_n = 1'b0;
      din = base + 18'(i);
      if (model.size() < DEPTH) model.push_back(din);
    end
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic drain(input int n, input string tag);
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [17:0] e;
      @(negedge rd_clk);
      if (i == n - 1) rd_en_n = 1'b1;
      e = model.pop_front();
      chk(dout == e, tag, 32'(dout), 32'(e));
    end
    last_out = dout;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    chk(dout == 18'd0, "R2 output register zero in reset", 32'(dout), 32'd0);
    chk(full_n && half_n && afull_n, "R3 write-side flags high in reset",
        {29'd0, full_n, half_n, afull_n}, 32'd7);
    chk(!empty_n && !aempty_n, "R3 read-side flags low in reset",
        {30'd0, empty_n, aempty_n}, 32'd0);
    @(negedge wr_clk);
    rst_n = 1'b1;
    settle();
    check_flags("after reset");
    last_out = dout;
  endtask

  task automatic t_first_word();
    fill(1, 18'h1A5A5);
    settle();
    chk(dout == 18'd0, "R6 first word not shown before read", 32'(dout), 32'd0);
    check_flags("one word");
    drain(1, "R5 R6 first word after request");
  endtask

  task automatic t_oe();
    @(negedge rd_clk);
    oe_n = 1'b1;
    #1;
    chk((dout === 18'bz) || (dout !== last_out), "R9 output released", 32'(dout), 32'(last_out));
    oe_n = 1'b0;
    #1;
    chk(dout == last_out, "R9 output driven", 32'(dout), 32'(last_out));
  endtask

  task automatic t_load_gate();
    @(negedge wr_clk);
    ld_n = 1'b0;
    fill(3, 18'h0BAD0);
    model.delete();
    ld_n = 1'b1;
    settle();
    chk(empty_n == 1'b0, "R4 no write while ld_n low", 32'(empty_n), 32'd0);
    fill(1, 18'h22222);
    settle();
    @(negedge rd_clk);
    ld_n = 1'b0;
    rd_en_n = 1'b0;
    repeat (3) @(negedge rd_clk);
    rd_en_n = 1'b1;
    ld_n = 1'b1;
    chk(dout == last_out, "R5 no read while ld_n low", 32'(dout), 32'(last_out));
    repeat (3) @(negedge rd_clk);
    chk(dout == last_out, "R5 hold with rd_en_n high", 32'(dout), 32'(last_out));
    drain(1, "R5 word kept through blocked read");
  endtask

  task automatic t_underflow();
    settle();
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    repeat (4) @(negedge rd_clk);
    rd_en_n = 1'b1;
    chk(dout == last_out, "R7 read while empty ignored", 32'(dout), 32'(last_out));
    fill(1, 18'h3C3C3);
    settle();
    drain(1, "R7 read position unchanged after empty reads");
  endtask

  task automatic t_thresholds();
    settle();
    fill(int'(E_OFS), 18'h10000);
    settle();
    check_flags("R10 count at empty offset");
    fill(1, 18'h10100);
    settle();
    check_flags("R10 count above empty offset");
    fill(DEPTH/2 - model.size(), 18'h11000);
    settle();
    check_flags("R11 count at half");
    fill(1, 18'h12000);
    settle();
    check_flags("R11 count above half");
    fill(DEPTH - int'(F_OFS) - 1 - model.size(), 18'h13000);
    settle();
    check_flags("R12 free above full offset");
    fill(1, 18'h14000);
    settle();
    check_flags("R12 free at full offset");
  endtask

  task automatic t_full();
    fill(DEPTH - model.size(), 18'h20000);
    settle();
    check_flags("R8 full");
    fill(4, 18'h3DEAD);
    settle();
    chk(model.size() == DEPTH, "R4 model full", model.size(), DEPTH);
    check_flags("R4 write while full");
    drain(DEPTH, "R1 R4 drain order no overwrite");
    settle();
    check_flags("R8 drained");
  endtask

  task automatic t_mixed();
    fill(5, 18'h05550);
    fill(7, 18'h07770);
    settle();
    drain(9, "R1 order across bursts");
    fill(2, 18'h09990);
    settle();
    drain(5, "R1 order after refill");
    settle();
    check_flags("R8 final");
  endtask

  initial begin
    rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; ld_n = 1'b1; oe_n = 1'b0;
    din = '0;
    t_reset();
    t_first_word();
    t_oe();
    t_load_gate();
    t_underflow();
    t_thresholds();
    t_full();
    t_mixed();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule